// File: doc/BRIEF.md
# Four-Channel Countdown Timer with APB Access

This peripheral holds several independent countdown channels behind an APB slave port. Each channel has a 64-byte register window and its own interrupt line. Software sets a start count and picks single-shot or repeating operation. Enabling the channel starts the count down. When the count expires, the channel raises a sticky event flag, and that flag drives the channel's interrupt unless the channel is masked.

Clearing the event flag is a handshake. A write of one to the clear register removes the flag and starts a short "clear busy" window. Clear writes that arrive inside that window are dropped. A separate reload register lets software restart the count from the start value at any moment, whatever data it writes there. The bus and all counters run on one clock.

Top module: `apb_multi_timer`

## Requirements
- R1: Channel c occupies bytes c*0x40 to c*0x40+0x3F. The offsets inside a window are: 0x08 start value (full width, read/write), 0x18 live count (read-only), 0x04 mode in bit 0 (1 = single-shot, 0 = repeating), 0x10 run enable in bit 0, 0x24 mask in bit 0, 0x00 event flag in bit 0 (read-only), 0x14 reload trigger (write-only, reads 0), and 0x20 clear register (bit 0 = event flag, bit 1 = clear busy). A write changes only the addressed register of the addressed channel.
- R2: A write of enable bit 0 = 1 to a stopped channel copies the start value into the counter on that edge. After that, at every clock edge where the stored enable was 1, a count above 1 decreases by exactly one.
- R3: In repeating mode, at the edge where the count is 1 the counter takes the start value and the event flag is set, so the period is the start value in clocks. With a start value of 0 the count stays at 0 and no event occurs.
- R4: In single-shot mode, at the edge where the count is 1 the counter becomes 0 and the event flag is set. The count then stays at 0 with no further event while the channel remains enabled.
- R5: A write of any data to the reload trigger copies the start value into the counter on that edge. This takes priority over counting.
- R6: The event flag stays set until a clear is accepted. It reads the same at offset 0x00 bit 0 and offset 0x20 bit 0.
- R7: A clear write with bit 0 = 1 while clear busy is 0 is accepted. It drops the event flag, and clear busy (0x20 bit 1) then reads 1 for the next two clocks.
- R8: A clear write with bit 0 = 0, or any clear write made while clear busy reads 1, leaves the event flag unchanged.
- R9: irq[c] is high exactly when channel c's event flag is 1 and its mask bit is 0.
- R10: Activity on one channel never alters the registers or count of another channel.
- R11: After reset every register and count reads 0 and every irq line is low.
- R12: Offsets outside the map read 0, and writes to them change nothing. Reads never change state.
- R13: If a timeout and an accepted clear fall on the same edge, the event flag stays set, and clear busy still starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock for the bus and all counters |
| presetn | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 8 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, valid while psel is high and pwrite is low |
| irq | output | 4 | Per-channel interrupt, level high |

## Verification
The count function is swept over every channel, both modes and a set of start values: 0, 1, 2, 3, 6 and the all-ones maximum. The live count and event flag are sampled at many distances from the enable edge. This separates the repeating wrap (start value minus distance modulo period) from the single-shot stop at zero, and it exposes off-by-one errors in period length and in the zero and all-ones start values. Directed sequences place clear writes at exact distances from timeouts. These show the busy window dropping a second clear while a fresh timeout lands, and a timeout beating a clear on the same edge. Separate sequences exercise reload writes with different data, mask toggling, and unmapped offsets.

// File: rtl/timer_pkg.sv
`timescale 1ns/1ps
package timer_pkg;

  // Byte offsets inside one channel window
  localparam logic [5:0] OFS_FLAG   = 6'h00;
  localparam logic [5:0] OFS_MODE   = 6'h04;
  localparam logic [5:0] OFS_START  = 6'h08;
  localparam logic [5:0] OFS_RUN    = 6'h10;
  localparam logic [5:0] OFS_RELOAD = 6'h14;
  localparam logic [5:0] OFS_COUNT  = 6'h18;
  localparam logic [5:0] OFS_CLEAR  = 6'h20;
  localparam logic [5:0] OFS_MASK   = 6'h24;

  // Write strobes from the bus control to one channel datapath
  typedef struct packed {
    logic mode;
    logic start;
    logic run;
    logic reload;
    logic clear;
    logic mask;
  } chanWr_t;

endpackage

// File: rtl/timer_chan_dp.sv
`timescale 1ns/1ps
module timer_chan_dp
  import timer_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int CLR_BUSY = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  chanWr_t          wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] startVal,
  output logic [CNT_W-1:0] countVal,
  output logic             singleMode,
  output logic             running,
  output logic             eventFlag,
  output logic             clrBusy,
  output logic             masked,
  output logic             irq
);

  localparam int BUSY_W = $clog2(CLR_BUSY + 1);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [BUSY_W-1:0] busyCnt;
  logic clrAccept;
  logic startEdge;
  logic timeout;

  assign clrAccept = wr.clear & wdata[0] & ~clrBusy;
  assign startEdge = wr.run & wdata[0] & ~running;
  assign timeout   = running & (countVal == ONE) & ~wr.reload;
  assign clrBusy   = (busyCnt != '0);
  assign irq       = eventFlag & ~masked;

  // configuration bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startVal   <= '0;
      singleMode <= 1'b0;
      running    <= 1'b0;
      masked     <= 1'b0;
    end else begin
      if (wr.start) startVal   <= wdata;
      if (wr.mode)  singleMode <= wdata[0];
      if (wr.run)   running    <= wdata[0];
      if (wr.mask)  masked     <= wdata[0];
    end
  end

  // live counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countVal <= '0;
    end else if (wr.reload || startEdge) begin
      countVal <= startVal;
    end else if (running) begin
      if (countVal == ONE || countVal == '0)
        countVal <= singleMode ? '0 : startVal;
      else
        countVal <= countVal - ONE;
    end
  end

  // event flag and clear handshake
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eventFlag <= 1'b0;
      busyCnt   <= '0;
    end else begin
      if (timeout)        eventFlag <= 1'b1;
      else if (clrAccept) eventFlag <= 1'b0;
      if (clrAccept)      busyCnt <= BUSY_W'(CLR_BUSY);
      else if (clrBusy)   busyCnt <= busyCnt - 1'b1;
    end
  end

  assert_dec_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (running && countVal > ONE && !wr.reload) |=> countVal == $past(countVal) - ONE);

  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rstN)
    (running && !singleMode && countVal == ONE && !wr.reload) |=> countVal == $past(startVal));

  assert_single_stop_R4: assert property (@(posedge clk) disable iff (!rstN)
    (running && singleMode && countVal <= ONE && !wr.reload) |=> countVal == '0);

  assert_reload_copy_R5: assert property (@(posedge clk) disable iff (!rstN)
    wr.reload |=> countVal == $past(startVal));

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (eventFlag && !(wr.clear && wdata[0])) |=> eventFlag);

  assert_busy_start_R7: assert property (@(posedge clk) disable iff (!rstN)
    clrAccept |=> clrBusy);

  assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rstN)
    (clrBusy && eventFlag) |=> eventFlag);

  assert_timeout_wins_R13: assert property (@(posedge clk) disable iff (!rstN)
    timeout |=> eventFlag);

endmodule

// File: rtl/timer_apb_ctrl.sv
`timescale 1ns/1ps
module timer_apb_ctrl
  import timer_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         psel,
  input  logic                         penable,
  input  logic                         pwrite,
  input  logic [ADDR_W-1:0]            paddr,
  input  logic [NUM_CH-1:0][CNT_W-1:0] startVals,
  input  logic [NUM_CH-1:0][CNT_W-1:0] countVals,
  input  logic [NUM_CH-1:0]            modeBits,
  input  logic [NUM_CH-1:0]            runBits,
  input  logic [NUM_CH-1:0]            flagBits,
  input  logic [NUM_CH-1:0]            busyBits,
  input  logic [NUM_CH-1:0]            maskBits,
  output chanWr_t [NUM_CH-1:0]         strobes,
  output logic [CNT_W-1:0]             prdata
);

  localparam int WIN_W    = 6;
  localparam int CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int SEL_HI   = WIN_W + CH_IDX_W;

  logic [WIN_W-1:0]    ofs;
  logic [CH_IDX_W-1:0] chIdx;
  logic upperZero;
  logic chanOk;
  logic hit;
  logic wrAcc;

  assign ofs   = paddr[WIN_W-1:0];
  assign chIdx = paddr[WIN_W +: CH_IDX_W];
  assign wrAcc = psel & penable & pwrite;

  generate
    if (ADDR_W > SEL_HI) begin : g_upper
      assign upperZero = (paddr[ADDR_W-1:SEL_HI] == '0);
    end else begin : g_noUpper
      assign upperZero = 1'b1;
    end
    if (NUM_CH == (1 << CH_IDX_W)) begin : g_fullIdx
      assign chanOk = 1'b1;
    end else begin : g_partIdx
      assign chanOk = (chIdx < CH_IDX_W'(NUM_CH));
    end
  endgenerate

  assign hit = upperZero & chanOk;

  always_comb begin
    strobes = '0;
    if (wrAcc && hit) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (chIdx == CH_IDX_W'(c)) begin
          case (ofs)
            OFS_MODE:   strobes[c].mode   = 1'b1;
            OFS_START:  strobes[c].start  = 1'b1;
            OFS_RUN:    strobes[c].run    = 1'b1;
            OFS_RELOAD: strobes[c].reload = 1'b1;
            OFS_CLEAR:  strobes[c].clear  = 1'b1;
            OFS_MASK:   strobes[c].mask   = 1'b1;
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    prdata = '0;
    if (psel && !pwrite && hit) begin
      case (ofs)
        OFS_FLAG:  prdata[0]   = flagBits[chIdx];
        OFS_MODE:  prdata[0]   = modeBits[chIdx];
        OFS_START: prdata      = startVals[chIdx];
        OFS_RUN:   prdata[0]   = runBits[chIdx];
        OFS_COUNT: prdata      = countVals[chIdx];
        OFS_CLEAR: prdata[1:0] = {busyBits[chIdx], flagBits[chIdx]};
        OFS_MASK:  prdata[0]   = maskBits[chIdx];
        default: ;
      endcase
    end
  end

  assert_one_target_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes));

  assert_read_no_write_R12: assert property (@(posedge clk) disable iff (!rstN)
    (psel && !pwrite) |-> (strobes == '0));

endmodule

// File: rtl/apb_multi_timer.sv
`timescale 1ns/1ps
module apb_multi_timer
  import timer_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int CNT_W    = 32,
  parameter int ADDR_W   = 8,
  parameter int CLR_BUSY = 2
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [CNT_W-1:0]  pwdata,
  output logic [CNT_W-1:0]  prdata,
  output logic [NUM_CH-1:0] irq
);

  chanWr_t [NUM_CH-1:0]         strobes;
  logic [NUM_CH-1:0][CNT_W-1:0] startVals;
  logic [NUM_CH-1:0][CNT_W-1:0] countVals;
  logic [NUM_CH-1:0]            modeBits;
  logic [NUM_CH-1:0]            runBits;
  logic [NUM_CH-1:0]            flagBits;
  logic [NUM_CH-1:0]            busyBits;
  logic [NUM_CH-1:0]            maskBits;

  timer_apb_ctrl #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk(pclk), .rstN(presetn),
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .startVals(startVals), .countVals(countVals),
    .modeBits(modeBits), .runBits(runBits), .flagBits(flagBits),
    .busyBits(busyBits), .maskBits(maskBits),
    .strobes(strobes), .prdata(prdata)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      timer_chan_dp #(
        .CNT_W(CNT_W), .CLR_BUSY(CLR_BUSY)
      ) u_chan (
        .clk(pclk), .rstN(presetn),
        .wr(strobes[c]), .wdata(pwdata),
        .startVal(startVals[c]), .countVal(countVals[c]),
        .singleMode(modeBits[c]), .running(runBits[c]),
        .eventFlag(flagBits[c]), .clrBusy(busyBits[c]),
        .masked(maskBits[c]), .irq(irq[c])
      );

      assert_irq_needs_flag_R9: assert property (@(posedge pclk) disable iff (!presetn)
        irq[c] |-> (flagBits[c] && !maskBits[c]));
    end
  endgenerate

endmodule

// File: tb/test_apb_multi_timer.sv
`timescale 1ns/1ps
module test_apb_multi_timer;

  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] A_FLAG = 6'h00, A_MODE = 6'h04, A_START = 6'h08,
                         A_RUN = 6'h10, A_RELOAD = 6'h14, A_COUNT = 6'h18,
                         A_CLEAR = 6'h20, A_MASK = 6'h24;

  logic clk = 1'b0;
  logic presetn = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [3:0]  irq;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int lastCommit = 0;
  int sampleCyc = 0;
  logic [3:0] sampleIrq;

  apb_multi_timer i_apb_multi_timer (
    .pclk(clk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic apbWrite(input int ch, input logic [5:0] ofs, input logic [31:0] data);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0;
    paddr = 8'(ch * 64) + {2'b00, ofs}; pwdata = data;
    @(negedge clk); penable = 1'b1;
    @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    lastCommit = cyc;
  endtask

  task automatic apbRead(input int ch, input logic [5:0] ofs, output logic [31:0] data);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0;
    paddr = 8'(ch * 64) + {2'b00, ofs};
    @(negedge clk); penable = 1'b1;
    #1; data = prdata; sampleCyc = cyc; sampleIrq = irq;
    @(negedge clk); psel = 1'b0; penable = 1'b0;
  endtask

  function automatic longint expCount(longint ld, bit single, longint k);
    if (ld == 0) return 0;
    if (single) return (k >= ld) ? 0 : ld - k;
    return ld - (k % ld);
  endfunction

  function automatic logic [31:0] sweepLoad(int i);
    case (i)
      0: return 32'd0;
      1: return 32'd1;
      2: return 32'd2;
      3: return 32'd3;
      4: return 32'd6;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  task automatic runCase(input int ch, input logic [31:0] ld, input bit single);
    logic [31:0] rd;
    int t0;
    longint k;
    apbWrite(ch, A_RUN, 32'd0);
    apbWrite(ch, A_CLEAR, 32'd1);
    apbWrite(ch, A_MASK, 32'd0);
    apbWrite(ch, A_MODE, {31'd0, single});
    apbWrite(ch, A_START, ld);
    apbWrite(ch, A_RUN, 32'd1);
    t0 = lastCommit;
    for (int r = 0; r < 6; r++) begin
      apbRead(ch, A_COUNT, rd);
      k = longint'(sampleCyc - t0);
      chk(single ? "R2/R4" : "R2/R3", $sformatf("count ch%0d load=%0h k=%0d", ch, ld, k),
          rd, 32'(expCount(longint'(ld), single, k)));
      apbRead(ch, A_FLAG, rd);
      k = longint'(sampleCyc - t0);
      chk("R6", $sformatf("flag ch%0d load=%0h k=%0d", ch, ld, k),
          rd, {31'd0, (ld != 0) && (k >= longint'(ld))});
      chk("R9", $sformatf("irq ch%0d load=%0h", ch, ld),
          {31'd0, sampleIrq[ch]}, {31'd0, (ld != 0) && (k >= longint'(ld))});
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL R11 watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd, held;
    int t0;
    repeat (3) @(negedge clk);
    presetn = 1'b1;
    @(negedge clk);

    // R11: reset state
    chk("R11", "irq after reset", {28'd0, irq}, 32'd0);
    for (int ch = 0; ch < 4; ch++) begin
      apbRead(ch, A_START, rd); chk("R11", "start", rd, 0);
      apbRead(ch, A_COUNT, rd); chk("R11", "count", rd, 0);
      apbRead(ch, A_MODE, rd);  chk("R11", "mode", rd, 0);
      apbRead(ch, A_CLEAR, rd); chk("R11", "clear reg", rd, 0);
      apbRead(ch, A_MASK, rd);  chk("R11", "mask", rd, 0);
    end

    // R1 / R12: readback and unmapped offsets
    apbWrite(3, A_START, 32'hA5A5_1234);
    apbWrite(3, A_MODE, 32'd1);
    apbWrite(3, A_MASK, 32'd1);
    apbWrite(3, 6'h0C, 32'hFFFF_FFFF);
    apbWrite(3, 6'h2C, 32'hFFFF_FFFF);
    apbRead(3, A_START, rd); chk("R1", "start readback", rd, 32'hA5A5_1234);
    apbRead(3, A_MODE, rd);  chk("R1", "mode readback", rd, 1);
    apbRead(3, A_MASK, rd);  chk("R1", "mask readback", rd, 1);
    apbRead(2, A_START, rd); chk("R1", "other window start", rd, 0);
    apbRead(3, 6'h0C, rd);   chk("R12", "unmapped read", rd, 0);
    apbRead(3, A_RELOAD, rd); chk("R12", "reload reads zero", rd, 0);
    apbRead(3, A_COUNT, rd); chk("R12", "count untouched", rd, 0);

    // R2/R3/R4/R6/R9: sweep
    for (int ch = 0; ch < 4; ch++)
      for (int m = 0; m < 2; m++)
        for (int li = 0; li < 6; li++)
          runCase(ch, sweepLoad(li), bit'(m));

    // R5 and R10: reload on ch1 while ch2 is held
    apbWrite(2, A_RUN, 32'd0);
    apbRead(2, A_COUNT, held);
    apbWrite(1, A_RUN, 32'd0);
    apbWrite(1, A_MODE, 32'd0);
    apbWrite(1, A_START, 32'd100);
    apbWrite(1, A_RUN, 32'd1);
    repeat (10) @(negedge clk);
    apbWrite(1, A_RELOAD, 32'd0);
    t0 = lastCommit;
    apbRead(1, A_COUNT, rd); chk("R5", "reload data 0", rd, 32'(100 - (sampleCyc - t0)));
    repeat (7) @(negedge clk);
    apbWrite(1, A_RELOAD, 32'hDEAD_BEEF);
    t0 = lastCommit;
    apbRead(1, A_COUNT, rd); chk("R5", "reload data other", rd, 32'(100 - (sampleCyc - t0)));
    apbRead(2, A_COUNT, rd); chk("R10", "held channel count", rd, held);
    apbRead(1, A_FLAG, rd);  chk("R10", "ch1 flag untouched", rd, 0);

    // R9: mask toggling with flag set (ch0 single, load 2)
    apbWrite(0, A_RUN, 32'd0);
    apbWrite(0, A_CLEAR, 32'd1);
    apbWrite(0, A_MODE, 32'd1);
    apbWrite(0, A_START, 32'd2);
    apbWrite(0, A_RUN, 32'd1);
    repeat (4) @(negedge clk);
    chk("R9", "irq unmasked", {31'd0, irq[0]}, 1);
    apbWrite(0, A_MASK, 32'd1);
    chk("R9", "irq masked", {31'd0, irq[0]}, 0);
    apbRead(0, A_FLAG, rd); chk("R6", "flag kept under mask", rd, 1);
    apbWrite(0, A_MASK, 32'd0);
    chk("R9", "irq unmasked again", {31'd0, irq[0]}, 1);

    // R8: clear with bit0 = 0
    repeat (3) @(negedge clk);
    apbWrite(0, A_CLEAR, 32'hFFFF_FFFE);
    apbRead(0, A_CLEAR, rd); chk("R8", "write zero ignored", rd, 32'b01);

    // R7: accepted clear, busy window
    repeat (3) @(negedge clk);
    apbWrite(0, A_CLEAR, 32'd1);
    apbRead(0, A_CLEAR, rd); chk("R7", "busy just after clear", rd, 32'b10);
    apbRead(0, A_CLEAR, rd); chk("R7", "busy over", rd, 32'b00);
    chk("R7", "irq after clear", {31'd0, irq[0]}, 0);

    // R8: second clear during busy dropped while timeout lands
    apbWrite(0, A_RUN, 32'd0);
    apbWrite(0, A_START, 32'd3);
    apbWrite(0, A_RUN, 32'd1);
    apbWrite(0, A_CLEAR, 32'd1);
    apbWrite(0, A_CLEAR, 32'd1);
    apbRead(0, A_FLAG, rd); chk("R8", "clear during busy ignored", rd, 1);
    apbRead(0, A_COUNT, rd); chk("R4", "single holds zero", rd, 0);
    apbWrite(0, A_CLEAR, 32'd1);
    apbRead(0, A_FLAG, rd); chk("R7", "later clear accepted", rd, 0);

    // R13: timeout on the same edge as an accepted clear
    apbWrite(3, A_RUN, 32'd0);
    apbWrite(3, A_MASK, 32'd0);
    apbWrite(3, A_MODE, 32'd0);
    apbWrite(3, A_START, 32'd1);
    apbWrite(3, A_RUN, 32'd1);
    repeat (4) @(negedge clk);
    apbWrite(3, A_CLEAR, 32'd1);
    apbRead(3, A_CLEAR, rd); chk("R13", "flag survives clear", rd, 32'b11);
    chk("R13", "irq stays", {31'd0, irq[3]}, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule